// File: doc/BRIEF.md
# Synchronized External-Clock Period Counter

This block is a period timer that lives in the system clock domain and counts rising edges of an asynchronous external clock pin. The edges pass through a programmable prescaler (ratios 1, 8, 64 or 256) and a two-flop synchronizer. A running count is compared against a period register. When the count lands on the period value, a sticky interrupt flag is raised, and the next qualified edge returns the count to zero. When the external source is not selected, the same path counts system clock cycles.

The build-time parameter `SYNC_AFTER_PS` picks where the synchronizer sits. With the value 1 the prescaler is clocked directly by the raw pin, its divided output is synchronized, and the first synchronized edge after enabling is swallowed. With the value 0 the raw pin is synchronized first, the prescaler counts synchronized edges, and counting starts on the first edge. Software programs the block through a four-word register interface with combinational read data. A sleep input freezes the synchronizer and stops all counting.

Top module: `sync_edge_timer`

## Requirements
- R1: While enabled with the external source selected, the count rises by exactly one for each qualified edge leaving the prescaler and synchronizer.
- R2: Prescale select values 0, 1, 2 and 3 give ratios 1, 8, 64 and 256. With ratio 1, every input edge is counted.
- R3: With `SYNC_AFTER_PS`=0, the pin is synchronized before the prescaler, and the prescaler's terminal count produces a tick every ratio edges starting from the first edge. The sync-enable bit has no effect in this variant.
- R4: With `SYNC_AFTER_PS`=1, the prescaler counts raw pin edges. Its output goes high on raw edge ratio/2 after a clear and then once every ratio edges. Ratio 1 passes the pin through. The first synchronized output edge after enabling is ignored. External counting happens only while the sync-enable bit is 1.
- R5: When the count equals the period, the next qualified edge loads zero instead of incrementing.
- R6: The flag is set one system clock cycle after counting brings the count onto the period value. From a count of zero, the first flag follows `period` edges and each later flag follows `period`+1 edges.
- R7: The flag stays at 1 until software writes 0 to it. A hardware set wins over a software clear in the same cycle.
- R8: A bus write to the count wins over an increment in the same cycle and clears the prescaler.
- R9: While the enable bit is 0, the count holds, the prescaler is held clear, and the ignore-first-edge state of R4 is re-armed.
- R10: While `sleepIn` is 1, the synchronizer flops hold their value and the count does not change.
- R11: With the external source deselected, the prescaler counts system clock cycles, and no edge is ignored.
- R12: Register addresses: 0 is control (bit 0 enable, bit 1 external source, bit 2 sync enable, bits 5:4 prescale select), 1 is count, 2 is period, 3 is flag (bit 0). Reset values are control 0, count 0, period 16'hFFFF and flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extClkIn | input | 1 | Asynchronous external clock pin |
| sleepIn | input | 1 | Freezes the synchronizer and counting while high |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | CNT_W (16) | Register write data |
| busRdData | output | CNT_W (16) | Combinational read data for `busAddr` |
| irqFlag | output | 1 | Sticky period-match flag |

## Verification
A prescaler that is off by one shows up as a count that is short or long after a burst of a known number of pin edges, and a different burst length makes the error visible at the next readback. If the ignore-first-edge state is wrong, the two build variants differ by the wrong amount right after the first edge following an enable. An error in the wrap or flag timing moves `irqFlag` by one edge or one cycle relative to the count. This becomes visible within one period by comparing the flag pin with the count read back after each pulse.

// File: rtl/sync_tmr_pkg.sv
package sync_tmr_pkg;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_COUNT  = 2'd1,
    A_PERIOD = 2'd2,
    A_FLAG   = 2'd3
  } tmr_addr_t;

  localparam int RUN_BIT  = 0;
  localparam int EXT_BIT  = 1;
  localparam int SYNC_BIT = 2;
  localparam int PS_LSB   = 4;

  typedef struct packed {
    logic [1:0] psSel;
    logic       syncOn;
    logic       extSel;
    logic       run;
  } tmr_ctrl_t;

  typedef struct packed {
    logic cntLoad;
    logic psClear;
  } tmr_strobe_t;

  function automatic int unsigned psRatio(input logic [1:0] sel);
    return (sel == 2'd3) ? 32'd256 : (32'd1 << (3 * sel));
  endfunction

endpackage

// File: rtl/sync_tmr_ctrl.sv
module sync_tmr_ctrl
  import sync_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  input  logic [CNT_W-1:0] countQ,
  input  logic             landQ,
  output tmr_ctrl_t        ctrlQ,
  output logic [CNT_W-1:0] periodQ,
  output tmr_strobe_t      strobe,
  output logic [CNT_W-1:0] busRdData,
  output logic             irqFlag
);

  logic wrCtrl, wrCount, wrPeriod, wrFlag;
  logic flagQ;

  assign wrCtrl   = busWrEn && (busAddr == A_CTRL);
  assign wrCount  = busWrEn && (busAddr == A_COUNT);
  assign wrPeriod = busWrEn && (busAddr == A_PERIOD);
  assign wrFlag   = busWrEn && (busAddr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ   <= '0;
      periodQ <= '1;
      flagQ   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlQ.run    <= busWrData[RUN_BIT];
        ctrlQ.extSel <= busWrData[EXT_BIT];
        ctrlQ.syncOn <= busWrData[SYNC_BIT];
        ctrlQ.psSel  <= busWrData[PS_LSB +: 2];
      end
      if (wrPeriod) periodQ <= busWrData;
      // hardware set dominates a software clear
      if (landQ)       flagQ <= 1'b1;
      else if (wrFlag) flagQ <= busWrData[0];
    end
  end

  always_comb begin
    strobe.cntLoad = wrCount;
    strobe.psClear = wrCount || !ctrlQ.run;
  end

  always_comb begin
    busRdData = '0;
    case (tmr_addr_t'(busAddr))
      A_CTRL: begin
        busRdData[RUN_BIT]     = ctrlQ.run;
        busRdData[EXT_BIT]     = ctrlQ.extSel;
        busRdData[SYNC_BIT]    = ctrlQ.syncOn;
        busRdData[PS_LSB +: 2] = ctrlQ.psSel;
      end
      A_COUNT:  busRdData = countQ;
      A_PERIOD: busRdData = periodQ;
      default:  busRdData[0] = flagQ;
    endcase
  end

  assign irqFlag = flagQ;

endmodule

// File: rtl/sync_tmr_datapath.sv
module sync_tmr_datapath
  import sync_tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int PS_W          = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SYNC_AFTER_PS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extClkIn,
  input  logic             sleepIn,
  input  tmr_ctrl_t        ctrlQ,
  input  tmr_strobe_t      strobe,
  input  logic [CNT_W-1:0] periodQ,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] countQ,
  output logic             landQ
);

  localparam bit AFTER    = (SYNC_AFTER_PS != 0);
  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [PS_W:0]   ratio;
  logic [PS_W-1:0] psLimit;
  assign ratio   = (PS_W+1)'(psRatio(ctrlQ.psSel));
  assign psLimit = PS_W'(ratio - 1'b1);

  // ---------------- synchronizer ----------------
  logic                   syncSrc;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else if (!sleepIn) begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], syncSrc};
      prevQ <= syncQ[SYNC_TOP];
    end
  end
  assign syncRise = syncQ[SYNC_TOP] && !prevQ;

  // -------- raw-pin prescaler (variant choice) --------
  generate
    if (AFTER) begin : g_after
      logic            psClrQ;
      logic            extRst;
      logic [PS_W-1:0] psCntExt;
      logic [PS_W:0]   half;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psClrQ <= 1'b1;
        else        psClrQ <= strobe.psClear;
      end
      assign extRst = !rst_n || psClrQ;

      always_ff @(posedge extClkIn or posedge extRst) begin
        if (extRst)                  psCntExt <= '0;
        else if (psCntExt == psLimit) psCntExt <= '0;
        else                         psCntExt <= psCntExt + 1'b1;
      end

      assign half    = ratio >> 1;
      assign syncSrc = (ratio == (PS_W+1)'(1)) ? extClkIn
                                               : ({1'b0, psCntExt} >= half);
    end else begin : g_before
      assign syncSrc = extClkIn;
    end
  endgenerate

  // -------- system-domain prescaler --------
  logic            sysPsIn;
  logic            sysPsTick;
  logic [PS_W-1:0] psCntSys;

  assign sysPsIn   = ctrlQ.extSel ? (!AFTER && syncRise) : 1'b1;
  assign sysPsTick = sysPsIn && (psCntSys == psLimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     psCntSys <= '0;
    else if (strobe.psClear)        psCntSys <= '0;
    else if (!sleepIn && sysPsIn)   psCntSys <= sysPsTick ? '0 : psCntSys + 1'b1;
  end

  // -------- qualification and first-edge skip --------
  logic rawTick, needPrime, primedQ, tick;

  assign needPrime = AFTER && ctrlQ.extSel;
  assign rawTick   = needPrime ? (ctrlQ.syncOn && syncRise) : sysPsTick;
  assign tick      = ctrlQ.run && !sleepIn && rawTick && (!needPrime || primedQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        primedQ <= 1'b0;
    else if (!ctrlQ.run)                               primedQ <= 1'b0;
    else if (!sleepIn && rawTick && needPrime)         primedQ <= 1'b1;
  end

  // -------- count register --------
  logic [CNT_W-1:0] nextCnt;
  assign nextCnt = (countQ == periodQ) ? '0 : countQ + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
      landQ  <= 1'b0;
    end else begin
      if (strobe.cntLoad) countQ <= loadData;
      else if (tick)      countQ <= nextCnt;
      landQ <= tick && !strobe.cntLoad && (nextCnt == periodQ);
    end
  end

endmodule

// File: rtl/sync_edge_timer.sv
module sync_edge_timer
  import sync_tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int PS_W          = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SYNC_AFTER_PS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extClkIn,
  input  logic             sleepIn,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic             irqFlag
);

  tmr_ctrl_t        ctrlQ;
  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] periodQ;
  logic             landQ;
  logic             runBit;

  assign runBit = ctrlQ.run;

  sync_tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .countQ    (countQ),
    .landQ     (landQ),
    .ctrlQ     (ctrlQ),
    .periodQ   (periodQ),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irqFlag   (irqFlag)
  );

  sync_tmr_datapath #(
    .CNT_W         (CNT_W),
    .PS_W          (PS_W),
    .SYNC_STAGES   (SYNC_STAGES),
    .SYNC_AFTER_PS (SYNC_AFTER_PS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .extClkIn (extClkIn),
    .sleepIn  (sleepIn),
    .ctrlQ    (ctrlQ),
    .strobe   (strobe),
    .periodQ  (periodQ),
    .loadData (busWrData),
    .countQ   (countQ),
    .landQ    (landQ)
  );

endmodule

// File: rtl/sync_edge_timer_chk.sv
module sync_edge_timer_chk
  import sync_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busWrEn,
  input logic [1:0]       busAddr,
  input logic             sleepIn,
  input logic             runBit,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] periodQ,
  input logic             irqFlag
);

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (countQ != $past(countQ)) && !$past(busWrEn) && ($past(countQ) != $past(periodQ))
      |-> countQ == CNT_W'($past(countQ) + 1'b1));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (countQ != $past(countQ)) && !$past(busWrEn) && ($past(countQ) == $past(periodQ))
      |-> countQ == '0);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (countQ != $past(countQ)) && !$past(busWrEn) && (countQ == periodQ)
      |=> irqFlag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irqFlag && !(busWrEn && (busAddr == A_FLAG)) |=> irqFlag);

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !runBit && !busWrEn |=> $stable(countQ));

  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleepIn && !busWrEn |=> $stable(countQ));

endmodule

bind sync_edge_timer sync_edge_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busWrEn (busWrEn),
  .busAddr (busAddr),
  .sleepIn (sleepIn),
  .runBit  (runBit),
  .countQ  (countQ),
  .periodQ (periodQ),
  .irqFlag (irqFlag)
);

// File: tb/tb_sync_edge_timer.sv
module tb_sync_edge_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        extClk = 1'b0;
  logic        sleepIn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'd0;
  logic [15:0] rdA, rdB;
  logic        irqA, irqB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // dut: synchronizer after prescaler; dutPre: synchronizer before prescaler
  sync_edge_timer dut (
    .clk(clk), .rst_n(rst_n), .extClkIn(extClk), .sleepIn(sleepIn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(rdA), .irqFlag(irqA)
  );

  sync_edge_timer #(.SYNC_AFTER_PS(0)) dutPre (
    .clk(clk), .rst_n(rst_n), .extClkIn(extClk), .sleepIn(sleepIn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(rdB), .irqFlag(irqB)
  );

  // control word bits: run=1, ext=2, sync=4, prescale select at bits 5:4
  localparam logic [15:0] C_RUN = 16'h0001;
  localparam logic [15:0] C_EXT = 16'h0002;
  localparam logic [15:0] C_SYN = 16'h0004;

  // {psSel, edges, expected count (after variant), expected count (before variant)}
  localparam logic [49:0] VEC [0:6] = '{
    {2'd0, 16'd5,   16'd4, 16'd5},
    {2'd0, 16'd1,   16'd0, 16'd1},
    {2'd1, 16'd20,  16'd2, 16'd2},
    {2'd1, 16'd7,   16'd0, 16'd0},
    {2'd1, 16'd8,   16'd0, 16'd1},
    {2'd2, 16'd100, 16'd1, 16'd1},
    {2'd3, 16'd300, 16'd0, 16'd1}
  };

  logic [1:0]  vPs;
  logic [15:0] vEdges, vExpA, vExpB, va, vb;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] xa, output logic [15:0] xb);
    @(negedge clk);
    busAddr = a;
    #1;
    xa = rdA; xb = rdB;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) extClk = 1'b1;
      repeat (4) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ctl, input logic [15:0] per);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd2, per);
    wr(2'd0, ctl);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset values
    rd(2'd0, va, vb); chk("R12 ctrl reset A", va, 16'h0); chk("R12 ctrl reset B", vb, 16'h0);
    rd(2'd1, va, vb); chk("R12 count reset A", va, 16'h0); chk("R12 count reset B", vb, 16'h0);
    rd(2'd2, va, vb); chk("R12 period reset A", va, 16'hFFFF); chk("R12 period reset B", vb, 16'hFFFF);
    rd(2'd3, va, vb); chk("R12 flag reset A", va, 16'h0); chk("R12 flag reset B", vb, 16'h0);
    chk("R12 irq pins reset", {14'd0, irqA, irqB}, 16'h0);

    // R1 R2 R3 R4: edge counts per prescale ratio for both variants
    for (int i = 0; i < 7; i++) begin
      {vPs, vEdges, vExpA, vExpB} = VEC[i];
      setup(C_RUN | C_EXT | C_SYN | (16'(vPs) << 4), 16'hFFFF);
      pulse(int'(vEdges));
      rd(2'd1, va, vb);
      chk("R1 R2 R4 table count after-variant", va, vExpA);
      chk("R1 R2 R3 table count before-variant", vb, vExpB);
    end

    // R4 sync enable off: after-variant holds, before-variant still counts
    setup(C_RUN | C_EXT, 16'hFFFF);
    pulse(4);
    rd(2'd1, va, vb);
    chk("R4 sync off after-variant", va, 16'd0);
    chk("R3 sync bit ignored before-variant", vb, 16'd4);

    // R5 R6 R7 period wrap and flag spacing, period 3
    setup(C_RUN | C_EXT | C_SYN, 16'd3);
    pulse(3);
    rd(2'd1, va, vb);
    chk("R6 first flag count B", vb, 16'd3);
    chk("R6 first flag pin B", {15'd0, irqB}, 16'd1);
    chk("R4 count A lags one edge", va, 16'd2);
    chk("R6 no flag yet A", {15'd0, irqA}, 16'd0);
    pulse(1);
    rd(2'd1, va, vb);
    chk("R5 wrap to zero B", vb, 16'd0);
    chk("R7 flag stays set B", {15'd0, irqB}, 16'd1);
    chk("R6 first flag A", {15'd0, irqA}, 16'd1);
    wr(2'd3, 16'h0000);
    rd(2'd3, va, vb);
    chk("R7 clear flag A", va, 16'd0);
    chk("R7 clear flag B", vb, 16'd0);
    pulse(2);
    chk("R6 no early flag B", {15'd0, irqB}, 16'd0);
    pulse(1);
    chk("R6 second flag after period+1 edges B", {15'd0, irqB}, 16'd1);
    chk("R6 no early flag A", {15'd0, irqA}, 16'd0);
    pulse(1);
    chk("R6 second flag A", {15'd0, irqA}, 16'd1);

    // R9 disable holds count and re-arms the first-edge skip
    setup(C_RUN | C_EXT | C_SYN, 16'hFFFF);
    pulse(2);
    wr(2'd0, C_EXT | C_SYN);
    pulse(3);
    rd(2'd1, va, vb);
    chk("R9 hold when disabled A", va, 16'd1);
    chk("R9 hold when disabled B", vb, 16'd2);
    wr(2'd0, C_RUN | C_EXT | C_SYN);
    pulse(2);
    rd(2'd1, va, vb);
    chk("R9 re-armed skip A", va, 16'd2);
    chk("R9 resume B", vb, 16'd4);

    // R10 sleep freezes counting
    setup(C_RUN | C_EXT | C_SYN, 16'hFFFF);
    @(negedge clk) sleepIn = 1'b1;
    pulse(5);
    rd(2'd1, va, vb);
    chk("R10 sleep hold A", va, 16'd0);
    chk("R10 sleep hold B", vb, 16'd0);
    @(negedge clk) sleepIn = 1'b0;
    repeat (4) @(negedge clk);
    pulse(3);
    rd(2'd1, va, vb);
    chk("R10 after wake A", va, 16'd2);
    chk("R10 after wake B", vb, 16'd3);

    // R11 internal source, ratio 8, about 84 enabled cycles
    setup(C_RUN | (16'd1 << 4), 16'hFFFF);
    repeat (83) @(posedge clk);
    wr(2'd0, 16'h0000);
    rd(2'd1, va, vb);
    chk("R11 internal count A", va, 16'd10);
    chk("R11 internal count B", vb, 16'd10);

    // R8 count write beats increment (internal source, ratio 1)
    setup(C_RUN, 16'hFFFF);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h0000);
    rd(2'd1, va, vb);
    chk("R8 write priority A", va, 16'd102);
    chk("R8 write priority B", vb, 16'd102);

    done = 1'b1;
    finishRun();
  end

endmodule